// File: doc/BRIEF.md
# Signed Comparison and Limit Test Unit

This block evaluates one of eight ladder-logic style tests on two's-complement operands and returns a single true/false answer. Six of the tests relate operand A to operand B: equality, inequality and the four ordered relations. A seventh checks that A and B agree in every bit that a mask word selects. The eighth is a window test: it checks a test value against a low and a high limit. When the low limit exceeds the high limit, the window wraps, and the test becomes an outside-band check.

A caller presents the operation code and every operand together with a one-cycle strobe. On the next clock edge the unit registers the answer and raises a valid flag for that single cycle. Between strobes the registered answer stays as it was, whatever happens on the inputs. Fetching operands from memory words is left to the surrounding logic.

Top module: `cmp_unit`

## Requirements
- R1: While reset is asserted, and right after it, out_valid and out_result are both 0.
- R2: The operation code is 3 bits: 0 equal, 1 not equal, 2 less, 3 less or equal, 4 greater, 5 greater or equal, 6 masked equal, 7 limit. out_valid is 1 in exactly the cycle after an in_valid strobe and 0 in the cycle after a cycle with no strobe.
- R3: Code 0 answers 1 only when opa equals opb. Code 1 always answers the opposite of code 0.
- R4: Codes 2 and 4 are strict ordered tests on signed values: opa < opb and opa > opb. Equal operands answer 0.
- R5: Codes 3 and 5 are inclusive ordered tests on signed values: opa <= opb and opa >= opb. Equal operands answer 1.
- R6: Code 6 answers 1 when (opa & mask) equals (opb & mask). An all-zero mask always answers 1.
- R7: For code 7 with lim_lo <= lim_hi (signed), the answer is 1 when lim_lo <= test_val <= lim_hi, bounds included.
- R8: For code 7 with lim_lo > lim_hi (signed), the answer is 1 when test_val >= lim_lo or test_val <= lim_hi.
- R9: In a cycle without a strobe, out_result keeps its value, and changes on op and on the operand inputs have no effect.
- R10: All operands are 16-bit two's complement, so 16'h8000 is the smallest value and 16'h7FFF the largest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: evaluate the current inputs |
| op | input | 3 | Operation code |
| opa | input | WIDTH | Operand A; source for masked equal |
| opb | input | WIDTH | Operand B; reference for masked equal |
| mask | input | WIDTH | Bit-select mask for masked equal |
| lim_lo | input | WIDTH | Low limit of the window |
| lim_hi | input | WIDTH | High limit of the window |
| test_val | input | WIDTH | Value tested against the window |
| out_valid | output | 1 | One-cycle flag: the result is new |
| out_result | output | 1 | Registered true/false answer |

## Verification
Ten operand values form a grid. They sit around the sign boundary (8000, 8001, FFFE, FFFF, 0000, 0001) and at the positive end, with two mid values. The six relational codes run over every pair in the grid. A signed and an unsigned comparison disagree on these pairs, and the pairs with equal operands separate the strict codes from the inclusive ones. The masked code runs over the same pairs with all-zero, all-one, low-byte, end-bit and alternating masks, which shows that only selected bits are compared. The limit code runs over every triple in the grid, so normal windows, wrapped windows and single-point windows are all tried, and test values land on each bound, just inside it and just outside it. After each strobe the inputs are scrambled with no strobe present, to show that the held answer does not move.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    typedef enum logic [2:0] {
        OP_EQ  = 3'd0,
        OP_NE  = 3'd1,
        OP_LT  = 3'd2,
        OP_LE  = 3'd3,
        OP_GT  = 3'd4,
        OP_GE  = 3'd5,
        OP_MEQ = 3'd6,
        OP_LIM = 3'd7
    } cmp_op_e;

    typedef struct packed {
        logic valid;
        logic result;
    } cmp_state_t;

endpackage

// File: rtl/cmp_relation.sv
// Signed relation of two words: equality and strict less-than.
module cmp_relation #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    output logic             is_eq,
    output logic             is_lt
);

    always_comb begin
        is_eq = (lhs == rhs);
        is_lt = ($signed(lhs) < $signed(rhs));
    end

endmodule

// File: rtl/cmp_masked.sv
// Equality restricted to the bit positions selected by a mask.
module cmp_masked #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] src,
    input  logic [WIDTH-1:0] ref_word,
    input  logic [WIDTH-1:0] sel,
    output logic             match
);

    logic [WIDTH-1:0] bit_diff;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign bit_diff[i] = sel[i] & (src[i] ^ ref_word[i]);
    end

    assign match = ~|bit_diff;

endmodule

// File: rtl/cmp_window.sv
// Window test; a wrapped window (low above high) selects the outside band.
module cmp_window #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] lo,
    input  logic [WIDTH-1:0] hi,
    input  logic [WIDTH-1:0] val,
    output logic             hit
);

    logic val_lt_lo, hi_lt_val, hi_lt_lo;
    logic unused_eq0, unused_eq1, unused_eq2;

    cmp_relation #(.WIDTH(WIDTH)) u_val_lo (
        .lhs(val), .rhs(lo), .is_eq(unused_eq0), .is_lt(val_lt_lo)
    );
    cmp_relation #(.WIDTH(WIDTH)) u_hi_val (
        .lhs(hi), .rhs(val), .is_eq(unused_eq1), .is_lt(hi_lt_val)
    );
    cmp_relation #(.WIDTH(WIDTH)) u_hi_lo (
        .lhs(hi), .rhs(lo), .is_eq(unused_eq2), .is_lt(hi_lt_lo)
    );

    logic above_lo, below_hi;

    always_comb begin
        above_lo = ~val_lt_lo;
        below_hi = ~hi_lt_val;
        if (hi_lt_lo) hit = above_lo | below_hi;
        else          hit = above_lo & below_hi;
    end

endmodule

// File: rtl/cmp_unit.sv
module cmp_unit
    import cmp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] lim_lo,
    input  logic [WIDTH-1:0] lim_hi,
    input  logic [WIDTH-1:0] test_val,
    output logic             out_valid,
    output logic             out_result
);

    logic ab_eq, ab_lt, mask_hit, win_hit;

    cmp_relation #(.WIDTH(WIDTH)) u_rel (
        .lhs(opa), .rhs(opb), .is_eq(ab_eq), .is_lt(ab_lt)
    );

    cmp_masked #(.WIDTH(WIDTH)) u_mask (
        .src(opa), .ref_word(opb), .sel(mask), .match(mask_hit)
    );

    cmp_window #(.WIDTH(WIDTH)) u_win (
        .lo(lim_lo), .hi(lim_hi), .val(test_val), .hit(win_hit)
    );

    cmp_state_t state_d, state_q;
    logic       eval;

    always_comb begin
        unique case (cmp_op_e'(op))
            OP_EQ:   eval = ab_eq;
            OP_NE:   eval = ~ab_eq;
            OP_LT:   eval = ab_lt;
            OP_LE:   eval = ab_lt | ab_eq;
            OP_GT:   eval = ~(ab_lt | ab_eq);
            OP_GE:   eval = ~ab_lt;
            OP_MEQ:  eval = mask_hit;
            OP_LIM:  eval = win_hit;
            default: eval = 1'b0;
        endcase

        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) state_d.result = eval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid  = state_q.valid;
    assign out_result = state_q.result;

endmodule

// File: rtl/cmp_unit_chk.sv
module cmp_unit_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       op,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [WIDTH-1:0] mask,
    input logic [WIDTH-1:0] lim_lo,
    input logic [WIDTH-1:0] lim_hi,
    input logic [WIDTH-1:0] test_val,
    input logic             out_valid,
    input logic             out_result
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_result)); // R1

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2

    AST_EQ_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd0) |=> (out_result == ($past(opa) == $past(opb)))); // R3

    AST_NE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd1) |=> (out_result == ($past(opa) != $past(opb)))); // R3

    AST_LT_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd2) |=>
        (out_result == ($signed($past(opa)) < $signed($past(opb))))); // R4

    AST_GE_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd5) |=>
        (out_result == ($signed($past(opa)) >= $signed($past(opb))))); // R5

    AST_MASKED_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd6) |=>
        (out_result == (($past(opa) & $past(mask)) == ($past(opb) & $past(mask))))); // R6

    AST_WINDOW_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd7 && $signed(lim_lo) <= $signed(lim_hi)) |=>
        (out_result == (($signed($past(test_val)) >= $signed($past(lim_lo))) &&
                        ($signed($past(test_val)) <= $signed($past(lim_hi)))))); // R7

    AST_WINDOW_WRAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd7 && $signed(lim_lo) > $signed(lim_hi)) |=>
        (out_result == (($signed($past(test_val)) >= $signed($past(lim_lo))) ||
                        ($signed($past(test_val)) <= $signed($past(lim_hi)))))); // R8

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result)); // R9

endmodule

bind cmp_unit cmp_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .opa(opa), .opb(opb), .mask(mask), .lim_lo(lim_lo), .lim_hi(lim_hi),
    .test_val(test_val), .out_valid(out_valid), .out_result(out_result)
);

// File: tb/cmp_unit_tb.sv
module cmp_unit_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   op = '0;
    logic [W-1:0] opa = '0, opb = '0, mask = '0;
    logic [W-1:0] lim_lo = '0, lim_hi = '0, test_val = '0;
    logic         out_valid, out_result;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk; // 200 MHz

    cmp_unit #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opa(opa), .opb(opb), .mask(mask), .lim_lo(lim_lo), .lim_hi(lim_hi),
        .test_val(test_val), .out_valid(out_valid), .out_result(out_result)
    );

    // R10: grid around the sign boundary and the positive end
    localparam logic [W-1:0] GRID [10] = '{
        16'h8000, 16'h8001, 16'hFFFE, 16'hFFFF, 16'h0000,
        16'h0001, 16'h0005, 16'h0008, 16'h7FFE, 16'h7FFF
    };
    localparam logic [W-1:0] MASKS [5] = '{
        16'h0000, 16'hFFFF, 16'h00FF, 16'h8001, 16'h5555
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%h b=%h m=%h lo=%h hi=%h tv=%h actual=%b expected=%b",
                     req, op, opa, opb, mask, lim_lo, lim_hi, test_val, act, exp);
        end
    endtask

    function automatic logic model(input logic [2:0] o, input logic [W-1:0] a, b, m, lo, hi, tv);
        int sa, sb, slo, shi, stv;
        sa = $signed(a); sb = $signed(b);
        slo = $signed(lo); shi = $signed(hi); stv = $signed(tv);
        case (o)
            3'd0: return sa == sb;
            3'd1: return sa != sb;
            3'd2: return sa < sb;
            3'd3: return sa <= sb;
            3'd4: return sa > sb;
            3'd5: return sa >= sb;
            3'd6: return (a & m) == (b & m);
            default: begin
                if (slo <= shi) return (stv >= slo) && (stv <= shi);
                else            return (stv >= slo) || (stv <= shi);
            end
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] o, input logic [W-1:0] lo, hi);
        case (o)
            3'd0, 3'd1: return "R3";
            3'd2, 3'd4: return "R4";
            3'd3, 3'd5: return "R5";
            3'd6:       return "R6";
            default:    return ($signed(lo) <= $signed(hi)) ? "R7" : "R8";
        endcase
    endfunction

    // One strobe, then one idle cycle with scrambled inputs.
    task automatic run(input logic [2:0] o, input logic [W-1:0] a, b, m, lo, hi, tv);
        logic exp;
        exp = model(o, a, b, m, lo, hi, tv);
        op = o; opa = a; opb = b; mask = m; lim_lo = lo; lim_hi = hi; test_val = tv;
        in_valid = 1'b1;
        @(negedge clk);
        check("R2 valid", out_valid, 1'b1);
        check(req_of(o, lo, hi), out_result, exp);
        in_valid = 1'b0;
        op = ~o; opa = ~a; opb = b + 16'd1; mask = ~m;
        lim_lo = hi; lim_hi = lo; test_val = ~tv;
        @(negedge clk);
        check("R2 single", out_valid, 1'b0);
        check("R9", out_result, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid", out_valid, 1'b0);
        check("R1 result", out_result, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid", out_valid, 1'b0);
        check("R1 result", out_result, 1'b0);

        // R3 R4 R5 R10: relational codes over every grid pair
        for (int o = 0; o < 6; o++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    run(3'(o), GRID[i], GRID[j], 16'h0000, 16'h0, 16'h0, 16'h0);

        // R6: masked equal
        for (int k = 0; k < 5; k++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    run(3'd6, GRID[i], GRID[j], MASKS[k], 16'h0, 16'h0, 16'h0);

        // R7 R8: limit test over every triple
        for (int l = 0; l < 10; l++)
            for (int h = 0; h < 10; h++)
                for (int t = 0; t < 10; t++)
                    run(3'd7, 16'h0, 16'h0, 16'h0, GRID[l], GRID[h], GRID[t]);

        // R8: explicit wrapped window lo=10, hi=6
        run(3'd7, 16'h0, 16'h0, 16'h0, 16'd10, 16'd6, 16'd8);
        run(3'd7, 16'h0, 16'h0, 16'h0, 16'd10, 16'd6, 16'd10);
        run(3'd7, 16'h0, 16'h0, 16'h0, 16'd10, 16'd6, 16'd6);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R2 actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule